// File: doc/BRIEF.md
# Two-Level Interrupt Status Collector

This block gathers single-cycle event pulses from power-management sources: idle timers, address traps and general-purpose pins. It latches each pulse into a status bit and drives one active-low interrupt line to the processor. The status is held in two levels. A top-level word reports fifteen direct sources. It also carries one summary bit that stands for a second-level word of timer and trap sources.

Each level can be read through two offsets. The mirror offset returns the bits and has no side effect. The clearing offset returns the same bits and drops them at the next clock edge. The interrupt line stays low for as long as any bit is latched at either level. The handler therefore reads the top word, follows the summary bit down, and clears both levels to release the line.

Top module: `smi_status_hub`

## Requirements
- R1: After reset, every status bit is clear, `smi_n` is high, and a read of any offset returns 0.
- R2: A pulse on `dir_evt[k]` latches a top-level bit. For k in 0..8 the bit is k. For k in 9..14 the bit is k+1. The bit is visible from the cycle after the pulse.
- R3: A pulse on `trap_evt[k]` (k in 0..5) latches second-level bit k, visible from the next cycle. Second-level bits 15:6 always read as 0.
- R4: Top-level bit 9 reads as 1 exactly while any second-level bit is set. It is never cleared on its own.
- R5: A read at offset 0x00 returns the top-level word and leaves all status unchanged.
- R6: A read at offset 0x02 returns the top-level word. At the following edge it clears the direct bits it returned.
- R7: A read at offset 0x04 returns the second-level word without side effects. A read at offset 0x06 returns the same word and clears the bits it returned at the following edge.
- R8: When an event pulse arrives in the same cycle as a clearing read of its bit, the bit stays set.
- R9: `smi_n` goes low in the cycle after any event pulse. It stays low until no bit at either level is latched.
- R10: With `rd_en` low, or at any offset other than 0x00, 0x02, 0x04 and 0x06, `rd_data` is 0 and no status changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read strobe, one cycle per access |
| rd_addr | input | 8 | Byte offset of the read |
| rd_data | output | 16 | Read data, combinational from the offset and status |
| dir_evt | input | 15 | Direct top-level event pulses |
| trap_evt | input | 6 | Second-level timer/trap event pulses |
| smi_n | output | 1 | Active-low interrupt request |

## Verification
Several rules are checked every cycle. The line falls after any pulse and rises only when both levels are empty. Mirror and unmapped reads never remove a bit. A clearing read leaves exactly the pulses of that cycle behind. Reserved second-level bits read as zero. The summary bit tracks the second level. The exact bit mapping of the direct events is shown only by the bench's scenarios and its reference model. So is the full handler walk, in which clearing the top word leaves the line low until the second level is read at its clearing offset.

// File: rtl/smi_hub_pkg.sv
package smi_hub_pkg;
  localparam int unsigned DATA_W  = 16;
  localparam int unsigned ADDR_W  = 8;
  localparam int unsigned SEC_W   = 6;
  localparam int unsigned SUM_BIT = 9;
  localparam int unsigned DIR_W   = DATA_W - 1;

  localparam logic [ADDR_W-1:0] OFS_TOP_MIR = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_TOP_RC  = 8'h02;
  localparam logic [ADDR_W-1:0] OFS_SEC_MIR = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_SEC_RC  = 8'h06;

  typedef enum logic [2:0] {
    VIEW_NONE,
    VIEW_TOP_MIR,
    VIEW_TOP_RC,
    VIEW_SEC_MIR,
    VIEW_SEC_RC
  } view_sel_e;
endpackage

// File: rtl/smi_rst_sync.sv
module smi_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/smi_stat_bank.sv
module smi_stat_bank #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] stat_q;
  logic [W-1:0] stat_d;
  logic         stat_en;

  // a pulse in the same cycle as a clear keeps its bit
  always_comb begin
    stat_en = (|set_i) | (|clr_i);
    stat_d  = (stat_q & ~clr_i) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= '0;
    else if (stat_en) stat_q <= stat_d;
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/smi_view_dec.sv
module smi_view_dec
  import smi_hub_pkg::*;
(
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output view_sel_e         sel
);
  always_comb begin
    sel = VIEW_NONE;
    if (rd_en) begin
      unique case (rd_addr)
        OFS_TOP_MIR: sel = VIEW_TOP_MIR;
        OFS_TOP_RC:  sel = VIEW_TOP_RC;
        OFS_SEC_MIR: sel = VIEW_SEC_MIR;
        OFS_SEC_RC:  sel = VIEW_SEC_RC;
        default:     sel = VIEW_NONE;
      endcase
    end
  end
endmodule

// File: rtl/smi_status_hub.sv
module smi_status_hub
  import smi_hub_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [DIR_W-1:0]  dir_evt,
  input  logic [SEC_W-1:0]  trap_evt,
  output logic              smi_n
);
  logic              rst_n_sync;
  view_sel_e         sel;
  logic [DIR_W-1:0]  dir_q;
  logic [DIR_W-1:0]  dir_clr;
  logic [SEC_W-1:0]  sec_q;
  logic [SEC_W-1:0]  sec_clr;
  logic [DATA_W-1:0] top_view;
  logic [DATA_W-1:0] sec_view;
  logic              sec_any;

  smi_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  smi_view_dec u_dec (
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .sel     (sel)
  );

  smi_stat_bank #(.W(DIR_W)) u_dir_bank (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .set_i  (dir_evt),
    .clr_i  (dir_clr),
    .stat_o (dir_q)
  );

  smi_stat_bank #(.W(SEC_W)) u_sec_bank (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .set_i  (trap_evt),
    .clr_i  (sec_clr),
    .stat_o (sec_q)
  );

  assign sec_any = |sec_q;

  // top word: direct bits around the summary position
  for (genvar i = 0; i < DATA_W; i++) begin : g_top
    if (i < SUM_BIT) begin : g_lo
      assign top_view[i] = dir_q[i];
    end else if (i == SUM_BIT) begin : g_sum
      assign top_view[i] = sec_any;
    end else begin : g_hi
      assign top_view[i] = dir_q[i-1];
    end
  end

  assign sec_view = {{(DATA_W-SEC_W){1'b0}}, sec_q};

  always_comb begin
    rd_data = '0;
    dir_clr = '0;
    sec_clr = '0;
    unique case (sel)
      VIEW_TOP_MIR: rd_data = top_view;
      VIEW_TOP_RC: begin
        rd_data = top_view;
        dir_clr = dir_q;
      end
      VIEW_SEC_MIR: rd_data = sec_view;
      VIEW_SEC_RC: begin
        rd_data = sec_view;
        sec_clr = sec_q;
      end
      default: rd_data = '0;
    endcase
  end

  assign smi_n = ~((|dir_q) | sec_any);
endmodule

// File: rtl/smi_status_chk.sv
module smi_status_chk
  import smi_hub_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [DATA_W-1:0] rd_data,
  input logic [DIR_W-1:0]  dir_evt,
  input logic [SEC_W-1:0]  trap_evt,
  input logic              smi_n,
  input logic [DIR_W-1:0]  dir_q,
  input logic [SEC_W-1:0]  sec_q
);
  logic mapped;
  assign mapped = (rd_addr == OFS_TOP_MIR) || (rd_addr == OFS_TOP_RC) ||
                  (rd_addr == OFS_SEC_MIR) || (rd_addr == OFS_SEC_RC);

  always @(posedge clk) begin
    if (!rst_n) a_reset_idle_r1: assert (smi_n);
  end

  p_evt_asserts_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((|dir_evt) || (|trap_evt)) |=> !smi_n);

  p_idle_releases_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((dir_q == '0) && (sec_q == '0)) |-> smi_n);

  p_mirror_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && ((rd_addr == OFS_TOP_MIR) || (rd_addr == OFS_SEC_MIR)))
    |=> (((dir_q & $past(dir_q)) == $past(dir_q)) &&
         ((sec_q & $past(sec_q)) == $past(sec_q))));

  p_top_rc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (rd_addr == OFS_TOP_RC)) |=> (dir_q == $past(dir_evt)));

  p_sec_rc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (rd_addr == OFS_SEC_RC)) |=> (sec_q == $past(trap_evt)));

  p_evt_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|trap_evt) |=> ((sec_q & $past(trap_evt)) == $past(trap_evt)));

  p_reserved_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && ((rd_addr == OFS_SEC_MIR) || (rd_addr == OFS_SEC_RC)))
    |-> (rd_data[DATA_W-1:SEC_W] == '0));

  p_summary_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (rd_addr == OFS_TOP_MIR)) |-> (rd_data[SUM_BIT] == (sec_q != '0)));

  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en || !mapped) |-> (rd_data == '0));

  p_unmapped_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en || !mapped)
    |=> (((dir_q & $past(dir_q)) == $past(dir_q)) &&
         ((sec_q & $past(sec_q)) == $past(sec_q))));
endmodule

bind smi_status_hub smi_status_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rd_en    (rd_en),
  .rd_addr  (rd_addr),
  .rd_data  (rd_data),
  .dir_evt  (dir_evt),
  .trap_evt (trap_evt),
  .smi_n    (smi_n),
  .dir_q    (dir_q),
  .sec_q    (sec_q)
);

// File: tb/test_smi_status_hub.sv
module test_smi_status_hub;
  logic        clk;
  logic        rst_n;
  logic        rd_en;
  logic [7:0]  rd_addr;
  logic [15:0] rd_data;
  logic [14:0] dir_evt;
  logic [5:0]  trap_evt;
  logic        smi_n;

  int n_chk;
  int n_fail;

  // reference state
  logic [14:0] m_dir;
  logic [5:0]  m_sec;

  smi_status_hub i_smi_status_hub (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .dir_evt  (dir_evt),
    .trap_evt (trap_evt),
    .smi_n    (smi_n)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [15:0] m_top();
    return {m_dir[14:9], |m_sec, m_dir[8:0]};
  endfunction

  function automatic logic [15:0] m_read(input logic en, input logic [7:0] a);
    if (!en) return 16'h0;
    case (a)
      8'h00, 8'h02: return m_top();
      8'h04, 8'h06: return {10'h0, m_sec};
      default:      return 16'h0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one cycle: drive, compare against the model, then advance the model
  task automatic step(input string tag, input logic [14:0] d, input logic [5:0] t,
                      input logic en, input logic [7:0] a);
    @(negedge clk);
    dir_evt = d; trap_evt = t; rd_en = en; rd_addr = a;
    #1;
    check(tag, rd_data, m_read(en, a));
    check(tag, {15'h0, smi_n}, {15'h0, ~((|m_dir) | (|m_sec))});
    @(posedge clk);
    if (en && a == 8'h02) m_dir = m_dir & ~m_dir;
    if (en && a == 8'h06) m_sec = m_sec & ~m_sec;
    m_dir = m_dir | d;
    m_sec = m_sec | t;
  endtask

  task automatic rd_expect(input string tag, input logic [7:0] a, input logic [15:0] exp);
    step(tag, '0, '0, 1'b1, a);
    check(tag, rd_data, exp);
  endtask

  task automatic smi_expect(input string tag, input logic exp);
    @(negedge clk);
    dir_evt = '0; trap_evt = '0; rd_en = 1'b0; rd_addr = '0;
    #1;
    check(tag, {15'h0, smi_n}, {15'h0, exp});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0;
    m_dir = '0; m_sec = '0;
    rst_n = 1'b0; rd_en = 1'b0; rd_addr = '0; dir_evt = '0; trap_evt = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    check("R1 smi idle in reset", {15'h0, smi_n}, 16'h1);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1: empty after reset
    rd_expect("R1 top mirror", 8'h00, 16'h0);
    rd_expect("R1 top clear", 8'h02, 16'h0);
    rd_expect("R1 sec mirror", 8'h04, 16'h0);
    rd_expect("R1 sec clear", 8'h06, 16'h0);
    smi_expect("R1 smi high", 1'b1);

    // R2/R5/R6: low direct bit, mirror then clear
    step("R2 pulse", 15'h0008, '0, 1'b0, 8'h00);
    smi_expect("R9 smi low", 1'b0);
    rd_expect("R2 bit3", 8'h00, 16'h0008);
    rd_expect("R5 mirror keeps", 8'h00, 16'h0008);
    rd_expect("R6 clear read", 8'h02, 16'h0008);
    rd_expect("R6 cleared", 8'h00, 16'h0000);
    smi_expect("R9 smi released", 1'b1);

    // R2: upper direct inputs skip bit 9
    step("R2 pulse hi", 15'h4200, '0, 1'b0, 8'h00);
    rd_expect("R2 bits 10 and 15", 8'h00, 16'h8400);
    rd_expect("R6 clear hi", 8'h02, 16'h8400);
    rd_expect("R6 cleared hi", 8'h00, 16'h0000);

    // R3/R4/R7/R9: second-level walk
    step("R3 pulse", '0, 6'h02, 1'b0, 8'h00);
    rd_expect("R3 sec bit1", 8'h04, 16'h0002);
    rd_expect("R4 summary", 8'h00, 16'h0200);
    rd_expect("R4 clear top", 8'h02, 16'h0200);
    rd_expect("R4 summary stays", 8'h00, 16'h0200);
    smi_expect("R9 still low", 1'b0);
    rd_expect("R7 sec clear", 8'h06, 16'h0002);
    rd_expect("R7 sec empty", 8'h04, 16'h0000);
    rd_expect("R4 summary gone", 8'h00, 16'h0000);
    smi_expect("R9 released both", 1'b1);

    // R3: all second-level sources, reserved bits zero
    step("R3 all traps", '0, 6'h3F, 1'b0, 8'h00);
    rd_expect("R3 reserved zero", 8'h06, 16'h003F);

    // R8: pulse during clearing read
    step("R8 set", 15'h0001, 6'h01, 1'b0, 8'h00);
    step("R8 collide sec", '0, 6'h01, 1'b1, 8'h06);
    rd_expect("R8 sec kept", 8'h04, 16'h0001);
    step("R8 collide top", 15'h0001, '0, 1'b1, 8'h02);
    rd_expect("R8 top kept", 8'h00, 16'h0201);

    // R10: unmapped and idle reads
    rd_expect("R10 odd offset", 8'h03, 16'h0000);
    rd_expect("R10 high offset", 8'h08, 16'h0000);
    rd_expect("R10 far offset", 8'hFF, 16'h0000);
    step("R10 strobe low", '0, '0, 1'b0, 8'h02);
    check("R10 strobe low data", rd_data, 16'h0000);
    rd_expect("R10 nothing cleared", 8'h00, 16'h0201);
    rd_expect("R10 sec untouched", 8'h04, 16'h0001);

    // mixed traffic against the model
    for (int i = 0; i < 400; i++) begin
      logic [14:0] d;
      logic [5:0]  t;
      logic [7:0]  a;
      d = (($urandom % 4) == 0) ? 15'(1 << ($urandom % 15)) : '0;
      t = (($urandom % 5) == 0) ? 6'(1 << ($urandom % 6)) : '0;
      a = 8'($urandom % 9);
      step("R2 R3 R6 R7 R8 mixed", d, t, ($urandom % 3) != 0, a);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule